// File: doc/BRIEF.md
# Counted Loop and Relative Branch Unit

This block resolves the next instruction pointer for two kinds of relative control transfer: an unconditional jump and a counted-loop instruction. The execution stage pulses `issue` once per operation. With that pulse it presents the current instruction address, the instruction length, a two-bit operation code, a signed displacement and the current 32-bit loop counter. One cycle later the block returns the next instruction pointer, the updated counter and a taken flag, and marks them with a one-cycle `done` strobe.

Every branch target is relative to the instruction that follows the branch. The target is `cur_ip + ins_len + disp`, computed modulo 2^32. The short jump and the loop use only the low byte of `disp`, sign-extended, which gives a reach of -128 to +127 bytes. The near jump uses all 32 bits. The loop operation first decrements the counter and then tests the new value. A loop is taken when that new value is nonzero. A starting count of zero therefore wraps to 0xFFFFFFFF and keeps looping.

The control is a two-state machine:
- `ST_IDLE` waits for `issue`. The transition `ST_IDLE -> ST_EXEC` occurs on `issue` and captures all operands.
- `ST_EXEC` registers the results and raises `done`. The transition `ST_EXEC -> ST_IDLE` is unconditional.

Top module: `loop_branch_unit`

## Requirements
- R1: After reset, `done`, `taken`, `next_ip` and `cnt_out` are all zero.
- R2: An `issue` sampled in `ST_IDLE` at clock edge k makes `done` high for exactly one cycle, beginning at edge k+1. The results are valid in that same cycle and hold until the next `done`.
- R3: Op code 2'b00 is the short jump. The target is `cur_ip + ins_len + sext(disp[7:0])`, `taken` is 1, and `cnt_out` equals `cnt_in`. Bits 31..8 of `disp` are ignored.
- R4: Op code 2'b01 is the near jump. The target is `cur_ip + ins_len + disp`, using all 32 bits of `disp`. `taken` is 1 and `cnt_out` equals `cnt_in`.
- R5: Op code 2'b10 is the loop. `cnt_out` is `cnt_in - 1`. `taken` is 1 exactly when `cnt_out` is nonzero. When taken, `next_ip` is `cur_ip + ins_len + sext(disp[7:0])`.
- R6: When a loop is not taken, `next_ip` is `cur_ip + ins_len`.
- R7: A loop issued with `cnt_in` equal to zero returns `cnt_out` = 0xFFFFFFFF and is taken.
- R8: Op code 2'b11 is reserved. It is never taken, `next_ip` is `cur_ip + ins_len`, and the counter is unchanged.
- R9: An `issue` that arrives while the unit is in `ST_EXEC` is ignored. It produces no second `done`, and the results reflect only the accepted operation.
- R10: All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | Start strobe for one operation |
| op | input | 2 | Operation: 00 short jump, 01 near jump, 10 loop, 11 reserved |
| cur_ip | input | 32 | Address of the branch instruction |
| ins_len | input | 4 | Length of the branch instruction in bytes |
| disp | input | 32 | Signed displacement (low byte only for short jump and loop) |
| cnt_in | input | 32 | Current loop counter |
| next_ip | output | 32 | Resolved next instruction pointer |
| cnt_out | output | 32 | Updated loop counter |
| taken | output | 1 | Branch taken |
| done | output | 1 | One-cycle result strobe |

## Verification
The loop is exercised with several starting counts:
- A count of 5 tells the taken path from the fall-through path.
- A count of 1 checks the exit from the loop.
- A count of 0 checks the decrement-before-test wrap.
- A count of 0xFFFFFFFF checks a large, nonzero count.

Short jumps use the displacement extremes 0x7F and 0x80, with nonzero upper bits in `disp`, to show that only the low byte is sign-extended. Near jumps use a positive displacement, a displacement that lands back on the branch itself, and an address near 0xFFFFFFFF to check modulo-2^32 wrap. A reserved op code and a back-to-back `issue` check the fall-through path and that a request arriving while busy is dropped.

// File: rtl/lbu_pkg.sv
package lbu_pkg;

    typedef enum logic [1:0] {
        OP_JSHORT = 2'b00,
        OP_JNEAR  = 2'b01,
        OP_LOOP   = 2'b10,
        OP_RSV    = 2'b11
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } st_e;

endpackage

// File: rtl/lbu_disp_sel.sv
module lbu_disp_sel
    import lbu_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SHORT_W = 8
) (
    input  op_e               op,
    input  logic [ADDR_W-1:0] disp_raw,
    output logic [ADDR_W-1:0] disp_ext
);
    localparam int PAD_W = ADDR_W - SHORT_W;

    logic [ADDR_W-1:0] short_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign short_ext = {{PAD_W{disp_raw[SHORT_W-1]}}, disp_raw[SHORT_W-1:0]};
        end else begin : g_nopad
            assign short_ext = disp_raw;
        end
    endgenerate

    always_comb begin
        if (op == OP_JNEAR) disp_ext = disp_raw;
        else                disp_ext = short_ext;
    end
endmodule

// File: rtl/lbu_ip_calc.sv
module lbu_ip_calc #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 4
) (
    input  logic [ADDR_W-1:0] cur_ip,
    input  logic [LEN_W-1:0]  ins_len,
    input  logic [ADDR_W-1:0] disp_ext,
    output logic [ADDR_W-1:0] fall_ip,
    output logic [ADDR_W-1:0] target_ip
);
    localparam int ZPAD = ADDR_W - LEN_W;

    logic [ADDR_W-1:0] len_ext;

    assign len_ext   = {{ZPAD{1'b0}}, ins_len};
    assign fall_ip   = cur_ip + len_ext;
    assign target_ip = fall_ip + disp_ext;
endmodule

// File: rtl/lbu_cnt_step.sv
module lbu_cnt_step
    import lbu_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  op_e              op,
    input  logic [CNT_W-1:0] cnt_cur,
    output logic [CNT_W-1:0] cnt_next,
    output logic             cnt_nz
);
    always_comb begin
        if (op == OP_LOOP) cnt_next = cnt_cur - {{(CNT_W-1){1'b0}}, 1'b1};
        else               cnt_next = cnt_cur;
        cnt_nz = (cnt_next != '0);
    end
endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
    import lbu_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 32,
    parameter int LEN_W   = 4,
    parameter int SHORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] cur_ip,
    input  logic [LEN_W-1:0]  ins_len,
    input  logic [ADDR_W-1:0] disp,
    input  logic [CNT_W-1:0]  cnt_in,
    output logic [ADDR_W-1:0] next_ip,
    output logic [CNT_W-1:0]  cnt_out,
    output logic              taken,
    output logic              done
);
    st_e               st_q, st_d;
    op_e               op_q;
    logic [ADDR_W-1:0] ip_q;
    logic [LEN_W-1:0]  len_q;
    logic [ADDR_W-1:0] disp_q;
    logic [CNT_W-1:0]  cnt_q;

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] fall_ip;
    logic [ADDR_W-1:0] target_ip;
    logic [CNT_W-1:0]  cnt_next;
    logic              cnt_nz;
    logic              take;
    logic              accept;

    assign accept = (st_q == ST_IDLE) && issue;

    // operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_RSV;
            ip_q   <= '0;
            len_q  <= '0;
            disp_q <= '0;
            cnt_q  <= '0;
        end else if (accept) begin
            op_q   <= op_e'(op);
            ip_q   <= cur_ip;
            len_q  <= ins_len;
            disp_q <= disp;
            cnt_q  <= cnt_in;
        end
    end

    lbu_disp_sel #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_disp (
        .op       (op_q),
        .disp_raw (disp_q),
        .disp_ext (disp_ext)
    );

    lbu_ip_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ip (
        .cur_ip    (ip_q),
        .ins_len   (len_q),
        .disp_ext  (disp_ext),
        .fall_ip   (fall_ip),
        .target_ip (target_ip)
    );

    lbu_cnt_step #(.CNT_W(CNT_W)) u_cnt (
        .op       (op_q),
        .cnt_cur  (cnt_q),
        .cnt_next (cnt_next),
        .cnt_nz   (cnt_nz)
    );

    always_comb begin
        unique case (op_q)
            OP_JSHORT, OP_JNEAR: take = 1'b1;
            OP_LOOP:             take = cnt_nz;
            OP_RSV:              take = 1'b0;
            default:             take = 1'b0;
        endcase
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (issue) st_d = ST_EXEC;
            ST_EXEC: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_ip <= '0;
            cnt_out <= '0;
            taken   <= 1'b0;
            done    <= 1'b0;
        end else if (st_q == ST_EXEC) begin
            next_ip <= take ? target_ip : fall_ip;
            cnt_out <= cnt_next;
            taken   <= take;
            done    <= 1'b1;
        end else begin
            done    <= 1'b0;
        end
    end
endmodule

// File: rtl/lbu_checker.sv
module lbu_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             issue,
    input logic             done,
    input logic             taken,
    input logic [CNT_W-1:0] cnt_out,
    input logic [1:0]       op_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             st_q
);
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_done_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(issue, 2));

    a_r5_loop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == 2'b10) |-> (cnt_out == cnt_q - {{(CNT_W-1){1'b0}}, 1'b1}));

    a_r5_loop_taken_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == 2'b10) |-> (taken == (cnt_out != '0)));

    a_r3_jump_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !op_q[1]) |-> (taken && cnt_out == cnt_q));

    a_r8_reserved_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == 2'b11) |-> (!taken && cnt_out == cnt_q));

    a_r9_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q && issue) |=> $stable(op_q));
endmodule

bind loop_branch_unit lbu_checker #(.CNT_W(CNT_W)) u_lbu_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (issue),
    .done    (done),
    .taken   (taken),
    .cnt_out (cnt_out),
    .op_q    (op_q),
    .cnt_q   (cnt_q),
    .st_q    (st_q)
);

// File: tb/loop_branch_unit_bench.sv
module loop_branch_unit_bench;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] ip;
        logic [3:0]  len;
        logic [31:0] disp;
        logic [31:0] cnt;
        logic [31:0] exp_ip;
        logic [31:0] exp_cnt;
        logic        exp_tk;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{2'b10, 32'h0000000C, 4'd2, 32'hFFFFFFFC, 32'd5,        32'h0000000A, 32'd4,        1'b1},
        '{2'b10, 32'h0000000C, 4'd2, 32'h000000FC, 32'd1,        32'h0000000E, 32'd0,        1'b0},
        '{2'b10, 32'h00001000, 4'd2, 32'h00000010, 32'd0,        32'h00001012, 32'hFFFFFFFF, 1'b1},
        '{2'b00, 32'h00002000, 4'd2, 32'hABCD007F, 32'd7,        32'h00002081, 32'd7,        1'b1},
        '{2'b00, 32'h00002000, 4'd2, 32'h12345680, 32'd7,        32'h00001F82, 32'd7,        1'b1},
        '{2'b01, 32'h00400000, 4'd5, 32'h00010000, 32'd9,        32'h00410005, 32'd9,        1'b1},
        '{2'b01, 32'h00400000, 4'd5, 32'hFFFFFFFB, 32'd9,        32'h00400000, 32'd9,        1'b1},
        '{2'b11, 32'h00003000, 4'd3, 32'h00000040, 32'd0,        32'h00003003, 32'd0,        1'b0},
        '{2'b01, 32'hFFFFFFF0, 4'd5, 32'h00000020, 32'd3,        32'h00000015, 32'd3,        1'b1},
        '{2'b10, 32'h00000010, 4'd2, 32'h00000002, 32'hFFFFFFFF, 32'h00000014, 32'hFFFFFFFE, 1'b1}
    };

    function automatic string tag_of(int i);
        case (i)
            0: return "R5";
            1: return "R6";
            2: return "R7";
            3: return "R3";
            4: return "R3";
            5: return "R4";
            6: return "R4";
            7: return "R8";
            8: return "R10";
            default: return "R5";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] cur_ip = '0;
    logic [3:0]  ins_len = '0;
    logic [31:0] disp = '0;
    logic [31:0] cnt_in = '0;
    logic [31:0] next_ip;
    logic [31:0] cnt_out;
    logic        taken;
    logic        done;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    loop_branch_unit u_loop_branch_unit (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue   (issue),
        .op      (op),
        .cur_ip  (cur_ip),
        .ins_len (ins_len),
        .disp    (disp),
        .cnt_in  (cnt_in),
        .next_ip (next_ip),
        .cnt_out (cnt_out),
        .taken   (taken),
        .done    (done)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic load(input vec_t v);
        op = v.op; cur_ip = v.ip; ins_len = v.len; disp = v.disp; cnt_in = v.cnt;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "done", {31'b0, done}, 32'd0);
        chk("R1", "taken", {31'b0, taken}, 32'd0);
        chk("R1", "next_ip", next_ip, 32'd0);
        chk("R1", "cnt_out", cnt_out, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            load(VEC[i]);
            issue = 1'b1;
            @(negedge clk);
            issue = 1'b0;
            chk("R2", "done early", {31'b0, done}, 32'd0);
            @(negedge clk);
            chk("R2", "done", {31'b0, done}, 32'd1);
            chk(tag_of(i), "next_ip", next_ip, VEC[i].exp_ip);
            chk(tag_of(i), "cnt_out", cnt_out, VEC[i].exp_cnt);
            chk(tag_of(i), "taken", {31'b0, taken}, {31'b0, VEC[i].exp_tk});
            @(negedge clk);
            chk("R2", "done width", {31'b0, done}, 32'd0);
            chk("R2", "hold next_ip", next_ip, VEC[i].exp_ip);
        end

        // R9: second issue while busy is dropped
        load(VEC[5]);
        issue = 1'b1;
        @(negedge clk);
        load(VEC[7]);
        @(negedge clk);
        issue = 1'b0;
        chk("R9", "done", {31'b0, done}, 32'd1);
        chk("R9", "next_ip", next_ip, VEC[5].exp_ip);
        chk("R9", "cnt_out", cnt_out, VEC[5].exp_cnt);
        @(negedge clk);
        chk("R9", "no second done", {31'b0, done}, 32'd0);
        @(negedge clk);
        chk("R9", "still no done", {31'b0, done}, 32'd0);
        chk("R9", "result kept", next_ip, VEC[5].exp_ip);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule